// File: doc/BRIEF.md
# Synchronized Microcontroller Register Bus

This block lets a small 8-bit microcontroller program and watch an acquisition path inside the chip. The microcontroller uses a multiplexed address/data bus. An active-high address strobe marks the address phase. Two active-low strobes mark reads and writes. None of these strobes is related to the chip clock.

The block never lets a strobe drive state directly. Each strobe first passes through a flop synchronizer. Its edges are then turned into single-cycle pulses. All register actions take place on those pulses, so the rest of the logic is fully synchronous.

The register bank has three entries. The control register holds a run bit and a self-clearing FIFO flush bit. The divider register holds a full-width sample-rate divider. The status register is read-only and reports whether the FIFO is empty or full. On a read, the block drives its output bus and raises an output enable while the synchronized read strobe is low. Outside that window the output enable is low, which models a tri-stated bus.

Top module: `mcu_regbus`

## Requirements
- R1: After reset, `acq_run` is 0, `fifo_flush` is 0, `mcu_ad_oe` is 0 and `rate_div` equals `DIV_RESET` (default 8'h04).
- R2: Each strobe passes through `SYNC_STAGES` flops before use. Each edge of a strobe produces exactly one single-cycle action, however long the strobe level is then held.
- R3: The register address is taken from `mcu_ad_i` on the falling edge of `mcu_ale`. Later changes on the bus do not alter the selected register until the next such edge.
- R4: A write takes place on the rising edge of `mcu_wr_n`. It stores the value present on `mcu_ad_i` at that time into the register selected by the latched address.
- R5: Address 0x00 bit 0 is the run bit. It drives `acq_run` and reads back in bit 0. The other bits of address 0x00 read as 0.
- R6: Writing 1 to bit 1 of address 0x00 gives exactly one clock cycle of `fifo_flush`. Writing 0 to that bit gives no pulse. The flush bit reads back as 0.
- R7: Address 0x01 holds the full 8-bit divider. It drives `rate_div` and reads back unchanged.
- R8: Address 0x02 reads `fifo_empty` in bit 0 and `fifo_full` in bit 1, with the upper bits 0. A write to address 0x02 changes nothing.
- R9: `mcu_ad_oe` is 1 only while the synchronized `mcu_rd_n` is low. While it is 1, `mcu_ad_o` carries the selected register. While it is 0, `mcu_ad_o` is 0.
- R10: Addresses 0x03 to 0xFF read as 0. Writes to them change no register or output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Chip clock |
| rst_n | input | 1 | Active-low reset |
| mcu_ale | input | 1 | Asynchronous address strobe, active high |
| mcu_rd_n | input | 1 | Asynchronous read strobe, active low |
| mcu_wr_n | input | 1 | Asynchronous write strobe, active low |
| mcu_ad_i | input | BUS_W | Incoming multiplexed address/data |
| mcu_ad_o | output | BUS_W | Read data driven toward the microcontroller |
| mcu_ad_oe | output | 1 | Output enable for the shared bus |
| fifo_empty | input | 1 | FIFO empty flag |
| fifo_full | input | 1 | FIFO full flag |
| acq_run | output | 1 | Acquisition enable |
| fifo_flush | output | 1 | One-cycle FIFO clear pulse |
| rate_div | output | BUS_W | Sample-rate divider |

## Verification
The hardest case to reach from the ports is a strobe held at one level for many clocks. A faulty edge detector would repeat the action on every cycle, yet the register value would look correct afterwards. The stimulus therefore holds the write strobe low for twenty cycles while writing the self-clearing flush bit, and it counts the `fifo_flush` cycles. It also changes the bus after the address phase and before a read, which shows that only the address strobe edge updates the address.

// File: rtl/mcu_regbus_pkg.sv
package mcu_regbus_pkg;
   // Register addresses; the microcontroller firmware decodes these.
   localparam int REG_CTRL = 0;
   localparam int REG_DIV  = 1;
   localparam int REG_STAT = 2;
   // Field positions inside the control and status registers.
   localparam int CTRL_RUN_BIT   = 0;
   localparam int CTRL_FLUSH_BIT = 1;
   localparam int STAT_EMPTY_BIT = 0;
   localparam int STAT_FULL_BIT  = 1;
   // Strobe indices inside the synchronizer array.
   localparam int STB_ALE = 0;
   localparam int STB_RD  = 1;
   localparam int STB_WR  = 2;
   localparam int STB_NUM = 3;
endpackage

// File: rtl/mcu_strobe_sync.sv
module mcu_strobe_sync #(
   parameter int   STAGES = 2,
   parameter logic IDLE   = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_in,
   output logic level,
   output logic rise,
   output logic fall
);
   localparam int LAST = STAGES - 1;

   if (STAGES < 2) begin : g_bad_stages
      $error("mcu_strobe_sync: STAGES must be at least 2");
   end

   logic [LAST:0] chain_q;
   logic          prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain_q <= {STAGES{IDLE}};
         prev_q  <= IDLE;
      end else begin
         chain_q <= {chain_q[LAST-1:0], async_in};
         prev_q  <= chain_q[LAST];
      end
   end

   assign level = chain_q[LAST];
   assign rise  = level & ~prev_q;
   assign fall  = ~level & prev_q;

   // R2: every edge pulse lasts one cycle
   a_r2_rise_single: assert property (@(posedge clk) disable iff (!rst_n)
      rise |=> !rise);
   a_r2_fall_single: assert property (@(posedge clk) disable iff (!rst_n)
      fall |=> !fall);
endmodule

// File: rtl/mcu_regfile.sv
module mcu_regfile
   import mcu_regbus_pkg::*;
#(
   parameter int         W         = 8,
   parameter logic [W-1:0] DIV_RESET = 8'h04
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr_stb,
   input  logic [W-1:0] wr_addr,
   input  logic [W-1:0] wr_data,
   input  logic [W-1:0] rd_addr,
   input  logic         fifo_empty,
   input  logic         fifo_full,
   output logic [W-1:0] rd_data,
   output logic         acq_run,
   output logic         fifo_flush,
   output logic [W-1:0] rate_div
);
   logic hit_ctrl, hit_div;

   assign hit_ctrl = wr_stb && (wr_addr == W'(REG_CTRL));
   assign hit_div  = wr_stb && (wr_addr == W'(REG_DIV));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acq_run    <= 1'b0;
         fifo_flush <= 1'b0;
         rate_div   <= DIV_RESET;
      end else begin
         fifo_flush <= hit_ctrl && wr_data[CTRL_FLUSH_BIT];
         if (hit_ctrl) acq_run  <= wr_data[CTRL_RUN_BIT];
         if (hit_div)  rate_div <= wr_data;
      end
   end

   always_comb begin
      rd_data = '0;
      if (rd_addr == W'(REG_CTRL)) begin
         rd_data[CTRL_RUN_BIT] = acq_run;
      end else if (rd_addr == W'(REG_DIV)) begin
         rd_data = rate_div;
      end else if (rd_addr == W'(REG_STAT)) begin
         rd_data[STAT_EMPTY_BIT] = fifo_empty;
         rd_data[STAT_FULL_BIT]  = fifo_full;
      end
   end

   // R6: flush is a one-cycle pulse
   a_r6_flush_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_flush |=> !fifo_flush);
   // R4: the divider changes only after a write strobe
   a_r4_div_on_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(rate_div) |-> $past(wr_stb));
   // R5: the run bit changes only after a write strobe
   a_r5_run_on_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(acq_run) |-> $past(wr_stb));
endmodule

// File: rtl/mcu_regbus.sv
module mcu_regbus
   import mcu_regbus_pkg::*;
#(
   parameter int             BUS_W       = 8,
   parameter int             SYNC_STAGES = 2,
   parameter logic [BUS_W-1:0] DIV_RESET   = 8'h04
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             mcu_ale,
   input  logic             mcu_rd_n,
   input  logic             mcu_wr_n,
   input  logic [BUS_W-1:0] mcu_ad_i,
   output logic [BUS_W-1:0] mcu_ad_o,
   output logic             mcu_ad_oe,
   input  logic             fifo_empty,
   input  logic             fifo_full,
   output logic             acq_run,
   output logic             fifo_flush,
   output logic [BUS_W-1:0] rate_div
);
   // Idle levels: ALE low, RD and WR high.
   localparam logic [STB_NUM-1:0] STB_IDLE = 3'b110;

   if (BUS_W < 2) begin : g_bad_width
      $error("mcu_regbus: BUS_W must hold the two status bits");
   end

   logic [STB_NUM-1:0] stb_raw, stb_lvl, stb_rise, stb_fall;
   logic [BUS_W-1:0]   addr_q, rd_data;

   assign stb_raw[STB_ALE] = mcu_ale;
   assign stb_raw[STB_RD]  = mcu_rd_n;
   assign stb_raw[STB_WR]  = mcu_wr_n;

   for (genvar g = 0; g < STB_NUM; g++) begin : g_sync
      mcu_strobe_sync #(.STAGES(SYNC_STAGES), .IDLE(STB_IDLE[g])) u_sync (
         .clk     (clk),
         .rst_n   (rst_n),
         .async_in(stb_raw[g]),
         .level   (stb_lvl[g]),
         .rise    (stb_rise[g]),
         .fall    (stb_fall[g])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) addr_q <= '0;
      else if (stb_fall[STB_ALE]) addr_q <= mcu_ad_i;
   end

   mcu_regfile #(.W(BUS_W), .DIV_RESET(DIV_RESET)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_stb    (stb_rise[STB_WR]),
      .wr_addr   (addr_q),
      .wr_data   (mcu_ad_i),
      .rd_addr   (addr_q),
      .fifo_empty(fifo_empty),
      .fifo_full (fifo_full),
      .rd_data   (rd_data),
      .acq_run   (acq_run),
      .fifo_flush(fifo_flush),
      .rate_div  (rate_div)
   );

   assign mcu_ad_oe = ~stb_lvl[STB_RD];
   assign mcu_ad_o  = mcu_ad_oe ? rd_data : '0;

   // R9: the output enable turns on only on a read-strobe falling pulse
   a_r9_oe_start: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mcu_ad_oe) |-> stb_fall[STB_RD]);
   // R9: the output bus is quiet while not enabled
   a_r9_quiet_bus: assert property (@(posedge clk) disable iff (!rst_n)
      !mcu_ad_oe |-> (mcu_ad_o == '0));
   // R3: the address register moves only on an address-strobe falling pulse
   a_r3_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(addr_q) |-> $past(stb_fall[STB_ALE]));
endmodule

// File: tb/mcu_regbus_bench.sv
module mcu_regbus_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       mcu_ale = 1'b0, mcu_rd_n = 1'b1, mcu_wr_n = 1'b1;
   logic [7:0] mcu_ad_i = '0;
   logic [7:0] mcu_ad_o, rate_div;
   logic       mcu_ad_oe, fifo_empty = 1'b1, fifo_full = 1'b0;
   logic       acq_run, fifo_flush;

   int checks = 0, errors = 0, flush_cnt = 0;
   bit done = 0;
   logic [7:0] exp_q[$], got_q[$];
   string      tag_q[$];

   always #4 clk = ~clk;

   mcu_regbus u_mcu_regbus (
      .clk(clk), .rst_n(rst_n), .mcu_ale(mcu_ale), .mcu_rd_n(mcu_rd_n),
      .mcu_wr_n(mcu_wr_n), .mcu_ad_i(mcu_ad_i), .mcu_ad_o(mcu_ad_o),
      .mcu_ad_oe(mcu_ad_oe), .fifo_empty(fifo_empty), .fifo_full(fifo_full),
      .acq_run(acq_run), .fifo_flush(fifo_flush), .rate_div(rate_div));

   task automatic check(string tag, logic [7:0] got, logic [7:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: got %h expected %h", tag, got, exp);
      end
   endtask

   task automatic idle(int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         if (fifo_flush) flush_cnt++;
      end
   endtask

   task automatic addr_phase(logic [7:0] a);
      @(negedge clk); mcu_ad_i = a; mcu_ale = 1'b1;
      idle(4);
      mcu_ale = 1'b0;
      idle(5);
   endtask

   task automatic bus_write(logic [7:0] a, logic [7:0] d, int low_cycles);
      addr_phase(a);
      mcu_ad_i = d; mcu_wr_n = 1'b0;
      flush_cnt = 0;
      idle(low_cycles);
      mcu_wr_n = 1'b1;
      idle(6);
   endtask

   // Driver: pushes the expected value, the monitor compares it.
   task automatic bus_read(logic [7:0] a, logic [7:0] exp, string tag);
      addr_phase(a);
      mcu_ad_i = 8'h5A;
      exp_q.push_back(exp); tag_q.push_back(tag);
      mcu_rd_n = 1'b0;
      idle(5);
      check({tag, " oe high"}, {7'd0, mcu_ad_oe}, 8'h01);
      got_q.push_back(mcu_ad_o);
      mcu_rd_n = 1'b1;
      idle(5);
      check("R9 oe low after read", {7'd0, mcu_ad_oe}, 8'h00);
   endtask

   // Monitor
   initial begin
      forever begin
         @(negedge clk);
         while (got_q.size() > 0 && exp_q.size() > 0)
            check(tag_q.pop_front(), got_q.pop_front(), exp_q.pop_front());
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      idle(3);
      rst_n = 1'b1;
      idle(4);
      // R1 reset state
      check("R1 acq_run", {7'd0, acq_run}, 8'h00);
      check("R1 fifo_flush", {7'd0, fifo_flush}, 8'h00);
      check("R1 oe", {7'd0, mcu_ad_oe}, 8'h00);
      check("R1 rate_div", rate_div, 8'h04);
      bus_read(8'h01, 8'h04, "R7 reset divider read");

      // R5 run bit
      bus_write(8'h00, 8'hFD, 4);
      check("R5 acq_run set", {7'd0, acq_run}, 8'h01);
      check("R6 no flush when bit1 is 0", flush_cnt[7:0], 8'h00);
      bus_read(8'h00, 8'h01, "R5 ctrl readback");

      // R6 flush pulse with a long write strobe (R2 single action)
      bus_write(8'h00, 8'h03, 20);
      check("R2 R6 one flush cycle", flush_cnt[7:0], 8'h01);
      check("R5 run kept", {7'd0, acq_run}, 8'h01);
      bus_read(8'h00, 8'h01, "R6 flush reads 0");

      // R7 divider patterns
      bus_write(8'h01, 8'hA5, 4);
      check("R4 R7 rate_div A5", rate_div, 8'hA5);
      bus_read(8'h01, 8'hA5, "R7 divider A5");
      bus_write(8'h01, 8'h5A, 4);
      check("R7 rate_div 5A", rate_div, 8'h5A);

      // R8 status
      fifo_empty = 1'b1; fifo_full = 1'b0;
      bus_read(8'h02, 8'h01, "R8 status empty");
      fifo_empty = 1'b0; fifo_full = 1'b1;
      bus_read(8'h02, 8'h02, "R8 status full");
      bus_write(8'h02, 8'hFF, 4);
      check("R8 write ignored div", rate_div, 8'h5A);
      check("R8 write ignored run", {7'd0, acq_run}, 8'h01);
      check("R8 write no flush", flush_cnt[7:0], 8'h00);

      // R10 unmapped
      bus_write(8'h7F, 8'h00, 4);
      check("R10 div unchanged", rate_div, 8'h5A);
      check("R10 run unchanged", {7'd0, acq_run}, 8'h01);
      bus_read(8'h03, 8'h00, "R10 read 03");
      bus_read(8'hFF, 8'h00, "R10 read FF");

      // R3 address held while bus changes without an address strobe
      addr_phase(8'h01);
      mcu_ad_i = 8'h00; idle(6);
      mcu_ad_i = 8'h02; idle(6);
      exp_q.push_back(8'h5A); tag_q.push_back("R3 address held");
      mcu_rd_n = 1'b0; idle(5);
      got_q.push_back(mcu_ad_o);
      mcu_rd_n = 1'b1; idle(5);

      // R9 bus quiet outside reads, run clear
      check("R9 ad_o zero when idle", mcu_ad_o, 8'h00);
      bus_write(8'h00, 8'h00, 4);
      check("R5 acq_run clear", {7'd0, acq_run}, 8'h00);

      idle(4);
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule